// File: doc/BRIEF.md
# Multichannel ADC Serial Output Formatter

This block takes one bank of simultaneously sampled 24-bit conversion results, up to eight channels wide, and shifts it out on serial data lines. A host supplies the serial clock and reads the bits. It does this in one of two framing styles. In the data-ready style, the block pulls an active-low ready flag down when a fresh bank is loaded. In the frame-sync style, the host sends a frame pulse, and each rising edge of that pulse starts a new frame.

A 3-bit format input selects the output arrangement. In multiplexed arrangements, all channels share line 0. A powered-down channel then either keeps its slot filled with zeros (fixed) or is removed so that later channels close the gap (dynamic). In the discrete arrangement, each channel has its own line. In multiplexed arrangements, once the local words are out, the bits on the serial input pass through to line 0, so several devices can be chained on one wire.

The serial clock and frame pulse are treated as slow signals that are already synchronous to the system clock. Both edges of each are detected in the system clock domain.

Top module: `adc_serial_formatter`

## Requirements
- R1: After reset, `drdy_n` is 1 and every `sdo` line is 0.
- R2: Channel c occupies `sample_bank[24c+23:24c]`. Each word is sent most significant bit first. In fixed multiplexed mode (`fmt[1:0]`=00), line 0 carries the slots for channels 0 to 7 in order, and lines 1 to 7 stay 0.
- R3: In fixed multiplexed mode, a channel whose `chan_off` bit is 1 still takes its 24-bit slot, and that slot is sent as zeros.
- R4: In dynamic multiplexed mode (`fmt[1:0]`=01), only channels whose `chan_off` bit is 0 are sent, in rising channel order, in back-to-back slots. With all channels off, no local bits are sent.
- R5: In discrete mode (`fmt[1]`=1), line c carries word c for 24 bit times. A powered-down channel's line carries zeros. Every line is 0 after the 24th bit.
- R6: In data-ready style (`fmt[2]`=0), `drdy_n` goes low within two clocks after `sample_valid` when no read is in progress. It returns high after the first rising edge of `sclk`.
- R7: In frame-sync style (`fmt[2]`=1), a rising edge on `fsync` loads the latest bank. Bit 0 is on the line before the first `sclk` rise. `drdy_n` stays high.
- R8: The data lines change only after a falling edge of `sclk` or a frame load, so the host may sample on the rising edge.
- R9: In multiplexed modes, every bit after the local words equals the level of `sdi` at the `sclk` falling edge that advanced to that bit. The pass-through bit is 0 before the first such edge.
- R10: A conversion that arrives during a read does not disturb the frame. In data-ready style it is loaded, and `drdy_n` falls, right after the last local bit is shifted. In frame-sync style it waits for the next `fsync` rise.
- R11: All words of a frame come from the bank captured at one `sample_valid` pulse. Later changes on `sample_bank` alone have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sample_valid | input | 1 | One-cycle strobe: a new bank is present |
| sample_bank | input | 192 | Eight 24-bit results, channel c at bits 24c+23..24c |
| chan_off | input | 8 | Per-channel power-down flag, 1 = off |
| fmt | input | 3 | [2] frame-sync style, [1] discrete, [0] dynamic slots |
| sclk | input | 1 | Host serial clock |
| fsync | input | 1 | Host frame pulse (frame-sync style) |
| sdi | input | 1 | Chained data from an upstream device |
| drdy_n | output | 1 | Active-low data-ready flag |
| sdo | output | 8 | Serial data lines; line 0 is the multiplexed line |

## Verification
Fixed multiplexing is run with two channels powered down, so a zero slot can be told apart from a missing slot. Dynamic multiplexing is run with a sparse enable mask and with every channel off, which separates correct compaction from a shifted slot and exercises pure pass-through. Discrete mode with one channel off shows that lines are routed per channel and go quiet after 24 bits. In both framing styles, a second bank arrives in the middle of a read, and a different value is left on the bank port. These runs tell apart a block that finishes the frame from one that reloads early or samples the port late.

// File: rtl/adc_serial_formatter.sv
module adc_serial_formatter #(
  parameter int NCH = 8,
  parameter int W   = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_valid,
  input  logic [NCH*W-1:0]     sample_bank,
  input  logic [NCH-1:0]       chan_off,
  input  logic [2:0]           fmt,
  input  logic                 sclk,
  input  logic                 fsync,
  input  logic                 sdi,
  output logic                 drdy_n,
  output logic [NCH-1:0]       sdo
);
  localparam int TOT = NCH * W;
  localparam int CW  = $clog2(TOT + 1) + 1;

  logic             sclk_q, fsync_q, pend, started, disc_r, chain_r;
  logic [TOT-1:0]   hold, frame, comp;
  logic [NCH-1:0]   offh;
  logic [CW-1:0]    cnt, len_r, len_c;

  wire sclk_rise  = sclk & ~sclk_q;
  wire sclk_fall  = ~sclk & sclk_q;
  wire fsync_rise = fsync & ~fsync_q;
  wire mid        = started && (cnt < len_r);
  wire dr_load    = pend && !mid && !fmt[2];
  wire fs_load    = fsync_rise && fmt[2];
  wire load       = dr_load || fs_load;

  always_comb begin : compose
    int k;
    comp = '0;
    k = 0;
    for (int c = 0; c < NCH; c++) begin
      if (!fmt[1] && fmt[0]) begin
        if (!offh[c]) begin
          comp[TOT-1-k*W -: W] = hold[c*W +: W];
          k++;
        end
      end else if (!offh[c]) begin
        comp[TOT-1-c*W -: W] = hold[c*W +: W];
      end
    end
    if (fmt[1])      len_c = CW'(W);
    else if (fmt[0]) len_c = CW'(k * W);
    else             len_c = CW'(TOT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      fsync_q <= 1'b0;
      hold    <= '0;
      offh    <= '0;
      frame   <= '0;
      len_r   <= '0;
      cnt     <= '0;
      pend    <= 1'b0;
      started <= 1'b0;
      disc_r  <= 1'b0;
      chain_r <= 1'b0;
      drdy_n  <= 1'b1;
    end else begin
      sclk_q  <= sclk;
      fsync_q <= fsync;
      if (sample_valid) begin
        hold <= sample_bank;
        offh <= chan_off;
      end
      if (sample_valid)  pend <= 1'b1;
      else if (dr_load)  pend <= 1'b0;
      if (load) begin
        frame   <= comp;
        len_r   <= len_c;
        disc_r  <= fmt[1];
        cnt     <= '0;
        chain_r <= 1'b0;
        started <= 1'b0;
      end else begin
        if (sclk_fall) begin
          if (cnt != '1) cnt <= cnt + 1'b1;
          chain_r <= sdi;
        end
        if (sclk_rise && !fmt[2]) started <= 1'b1;
      end
      if (dr_load)        drdy_n <= 1'b0;
      else if (sclk_rise) drdy_n <= 1'b1;
    end
  end

  always_comb begin
    sdo = '0;
    for (int i = 0; i < NCH; i++) begin
      if (disc_r) begin
        if (int'(cnt) < W) sdo[i] = frame[TOT-1-i*W-int'(cnt)];
      end else if (i == 0) begin
        sdo[0] = (cnt < len_r) ? frame[TOT-1-int'(cnt)] : chain_r;
      end
    end
  end
endmodule

// File: rtl/adc_serial_formatter_chk.sv
module adc_serial_formatter_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sclk,
  input logic           fsync,
  input logic [2:0]     fmt,
  input logic           drdy_n,
  input logic [NCH-1:0] sdo
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (drdy_n && sdo == '0));

  // R6
  drdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n) |-> ($past(sclk) && !$past(sclk, 2)));

  // R7
  drdy_fs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> !$past(fmt[2]));

  // R8
  sdo_causal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> (($past(!sclk) && $past(sclk, 2)) ||
                       ($past(fsync) && !$past(fsync, 2)) || !drdy_n));
endmodule

bind adc_serial_formatter adc_serial_formatter_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync),
  .fmt(fmt), .drdy_n(drdy_n), .sdo(sdo)
);

// File: tb/sim_adc_serial_formatter.sv
module sim_adc_serial_formatter;
  localparam int CLK_P = 10;
  localparam int NCH = 8;
  localparam int W   = 24;
  localparam int TOT = NCH * W;
  localparam logic [31:0] PAT = 32'hC3A5_96E4;

  logic clk = 0, rst_n = 0, sample_valid = 0, sclk = 0, fsync = 0, sdi = 0;
  logic [TOT-1:0] sample_bank = '0;
  logic [NCH-1:0] chan_off = '0;
  logic [2:0]     fmt = 3'b000;
  logic           drdy_n;
  logic [NCH-1:0] sdo;

  int total = 0, fails = 0;
  logic [NCH-1:0] exp_q[$];
  string          tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  adc_serial_formatter #(.NCH(NCH), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .sample_bank(sample_bank), .chan_off(chan_off), .fmt(fmt),
    .sclk(sclk), .fsync(fsync), .sdi(sdi), .drdy_n(drdy_n), .sdo(sdo));

  task automatic check1(input logic [31:0] act, input logic [31:0] expv, input string tg);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tg, act, expv);
    end
  endtask

  // Monitor: compare each bit the host samples on a rising serial clock
  always @(posedge sclk) begin
    if (exp_q.size() != 0) begin
      logic [NCH-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (sdo !== e) begin
        fails++;
        $display("FAIL %s: got %0h expected %0h", t, sdo, e);
      end
    end
  end

  function automatic logic [TOT-1:0] mkbank(input int seed);
    logic [TOT-1:0] b;
    for (int c = 0; c < NCH; c++)
      b[c*W +: W] = W'(seed * 32'h9E37 + c * 32'h10F1B + 32'h5A5A5);
    return b;
  endfunction

  // Expected stream, driver side of the scoreboard
  task automatic push_frame(input logic [TOT-1:0] bank, input logic [NCH-1:0] off,
                            input logic [2:0] f, input int first, input int n, input string ovr);
    logic [W-1:0] sw[NCH];
    logic [NCH-1:0] v;
    int ns = 0, len;
    string tg;
    for (int c = 0; c < NCH; c++) begin
      if (!f[1] && f[0]) begin
        if (!off[c]) begin sw[ns] = bank[c*W +: W]; ns++; end
      end else begin
        sw[ns] = off[c] ? '0 : bank[c*W +: W]; ns++;
      end
    end
    len = f[1] ? W : ns * W;
    for (int b = first; b < first + n; b++) begin
      v = '0;
      if (f[1]) begin
        for (int c = 0; c < NCH; c++)
          if (b < W && !off[c]) v[c] = bank[c*W + W-1-b];
        tg = "R5";
      end else if (b < len) begin
        v[0] = sw[b/W][W-1-(b%W)];
        tg = f[0] ? "R4" : (off[b/W] ? "R3" : "R2");
      end else begin
        v[0] = PAT[b%32];
        tg = "R9";
      end
      if (ovr != "" && b < len) tg = ovr;
      exp_q.push_back(v);
      tag_q.push_back(tg);
    end
  endtask

  // R11: bank port is overwritten right after the capture strobe
  task automatic convert(input logic [TOT-1:0] bank, input logic [NCH-1:0] off);
    @(negedge clk);
    sample_bank = bank; chan_off = off; sample_valid = 1;
    @(negedge clk);
    sample_valid = 0; sample_bank = ~bank;
  endtask

  task automatic read_bits(input int n, input bit chk_dr);
    for (int k = 0; k < n; k++) begin
      logic [NCH-1:0] at_rise;
      repeat (2) @(negedge clk);
      sclk = 1;
      at_rise = sdo;
      repeat (2) @(negedge clk);
      if (k < 4) check1(sdo, at_rise, "R8");
      if (chk_dr && k == 0) check1(drdy_n, 1, "R6");
      sdi = PAT[(k+1)%32];
      sclk = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic fs_pulse();
    @(negedge clk); fsync = 1;
    repeat (4) @(negedge clk); fsync = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [TOT-1:0] a, b;
    repeat (5) @(negedge clk);
    check1(drdy_n, 1, "R1");
    check1(sdo, 0, "R1");
    rst_n = 1;
    repeat (2) @(negedge clk);
    check1(drdy_n, 1, "R1");
    check1(sdo, 0, "R1");

    // fixed multiplexed, channels 0 and 2 off, chain tail
    fmt = 3'b000;
    a = mkbank(1);
    convert(a, 8'b0000_0101);
    repeat (2) @(negedge clk);
    check1(drdy_n, 0, "R6");
    push_frame(a, 8'b0000_0101, 3'b000, 0, TOT + 6, "");
    read_bits(TOT + 6, 1);
    check1(exp_q.size(), 0, "R2");

    // dynamic, sparse mask
    fmt = 3'b001;
    a = mkbank(2);
    convert(a, 8'b1001_0010);
    repeat (3) @(negedge clk);
    push_frame(a, 8'b1001_0010, 3'b001, 0, 5*W + 6, "");
    read_bits(5*W + 6, 1);

    // dynamic, all channels off: pure pass-through
    a = mkbank(3);
    convert(a, 8'hFF);
    repeat (3) @(negedge clk);
    check1(drdy_n, 0, "R6");
    push_frame(a, 8'hFF, 3'b001, 0, 10, "R4");
    read_bits(10, 1);

    // discrete, channel 3 off
    fmt = 3'b010;
    a = mkbank(4);
    convert(a, 8'b0000_1000);
    repeat (3) @(negedge clk);
    push_frame(a, 8'b0000_1000, 3'b010, 0, W + 3, "");
    read_bits(W + 3, 1);

    // frame-sync, new bank mid-read must wait for next pulse (R10)
    fmt = 3'b100;
    a = mkbank(5);
    b = mkbank(6);
    convert(a, 8'h00);
    repeat (3) @(negedge clk);
    check1(drdy_n, 1, "R7");
    fs_pulse();
    check1(sdo[0], a[W-1], "R7");
    push_frame(a, 8'h00, 3'b100, 0, TOT, "R10");
    fork
      read_bits(TOT, 0);
      begin repeat (200) @(negedge clk); convert(b, 8'h00); end
    join
    check1(drdy_n, 1, "R7");
    fs_pulse();
    check1(sdo[0], b[W-1], "R10");
    push_frame(b, 8'h00, 3'b100, 0, 48, "R11");
    read_bits(48, 0);

    // data-ready, new bank mid-read completes frame first (R10)
    fmt = 3'b000;
    repeat (4) @(negedge clk);
    a = mkbank(7);
    b = mkbank(8);
    convert(a, 8'h00);
    repeat (3) @(negedge clk);
    check1(drdy_n, 0, "R6");
    push_frame(a, 8'h00, 3'b000, 0, TOT, "R10");
    fork
      read_bits(100, 1);
      begin repeat (120) @(negedge clk); convert(b, 8'h00); end
    join
    check1(drdy_n, 1, "R10");
    read_bits(TOT - 100, 0);
    check1(drdy_n, 0, "R10");
    push_frame(b, 8'h00, 3'b000, 0, TOT, "R11");
    read_bits(TOT, 1);
    check1(exp_q.size(), 0, "R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    total++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule